// File: doc/BRIEF.md
# Segmented Address Translator with Protection Checks

This block turns a segmented address into a flat 32-bit linear address. A segmented address is a 16-bit selector plus a 32-bit offset. The block holds two small descriptor tables, a global one and a local one. Software fills both through a write port. Each descriptor entry stores a base, a limit (the largest legal offset), read, write and execute permissions, and a privilege level.

A requester presents a selector, an offset, an access kind and its current privilege level. The request and the response each use a valid/ready handshake. The block decodes the selector and picks the table and the entry. It then checks the entry's limit, rights and privilege, in a fixed order. It returns one of two results:
- the linear address, when every check passes;
- a fault code, when any check fails.

The result is registered one cycle after the request is accepted. A result that has not been taken is held until the consumer takes it.

Top module: `seg_xlate`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request through a global-table selector (bit 2 = 0, index = bits 15:3) returns base + offset with fault code 0. The response appears on the clock edge after the edge that accepts the request.
- R3: A selector with bit 2 = 1 reads the local table. Local index 0 is an ordinary entry, not a null selector.
- R4: An offset equal to the entry limit passes. An offset one above the limit returns fault code 1 (limit).
- R5: A selector index at or above the table depth (16 entries) returns fault code 1.
- R6: Access kinds are coded 0 = read, 1 = write, 2 = execute and 3 = reserved. The first three are allowed only if the entry grants that right. Kind 3 is never allowed. A refused access returns fault code 2 (rights).
- R7: The privilege check passes only when max(cpl, rpl) <= dpl, where rpl is selector bits 1:0. If it fails, the block returns fault code 3.
- R8: Global index 0 (selector bits 15:2 all zero) is the null selector. It always returns fault code 4, whatever was loaded into that entry.
- R9: When several checks fail, the block reports one fault by priority: null first, then limit, then rights, then privilege.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the result is held stable and `req_ready` is 0. Once `rsp_ready` is 1, a new request can be accepted on the same edge that retires the old result.
- R11: Whenever the fault code is nonzero, `rsp_addr` is 0.
- R12: The sum base + offset wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one descriptor entry |
| cfg_local | input | 1 | Table to write: 0 = global, 1 = local |
| cfg_idx | input | 4 | Entry index to write |
| cfg_base | input | 32 | Segment base |
| cfg_limit | input | 32 | Largest legal offset |
| cfg_rd | input | 1 | Read permitted |
| cfg_wr | input | 1 | Write permitted |
| cfg_ex | input | 1 | Execute permitted |
| cfg_dpl | input | 2 | Descriptor privilege level |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_sel | input | 16 | Selector |
| req_off | input | 32 | Offset |
| req_kind | input | 2 | Access kind |
| req_cpl | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Linear address (0 on fault) |
| rsp_fault | output | 3 | 0 none, 1 limit, 2 rights, 3 privilege, 4 null |

## Verification
The bench targets the off-by-one point of the limit compare: an offset equal to the limit passes and the offset one above it faults. A design using `>=` instead of `>` would fault on the first. It probes the null selector with a permissive entry 0 loaded, and local index 0 loaded too. A design that ignores the table bit, or tests only the index, would either pass the null access or fault the local one. It uses entries that fail several checks at once, to catch a wrong fault priority. It uses requesters where either cpl or rpl alone exceeds dpl, to catch a privilege check that looks at only one of them. A final scenario stalls the consumer while a second request waits. A design that drops or overwrites a held result, or accepts the waiting request too early, shows a changed output or a lost response.

// File: rtl/seg_pkg.sv
package seg_pkg;
   localparam int ADDR_W = 32;

   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_LIMIT  = 3'd1,
      FLT_RIGHTS = 3'd2,
      FLT_PRIV   = 3'd3,
      FLT_NULL   = 3'd4
   } fault_e;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef struct packed {
      logic [ADDR_W-1:0] base;
      logic [ADDR_W-1:0] limit;
      logic              rd;
      logic              wr;
      logic              ex;
      logic [1:0]        dpl;
   } desc_t;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
   import seg_pkg::*;
#(
   parameter int ENTRIES = 16,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  desc_t            wr_desc,
   input  logic [IDX_W-1:0] rd_idx,
   output desc_t            rd_desc
);
   desc_t slot [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot[e] <= '0;
         else if (wr_en && wr_idx == IDX_W'(e))
            slot[e] <= wr_desc;
      end
   end

   assign rd_desc = slot[rd_idx];
endmodule

// File: rtl/seg_rule_check.sv
module seg_rule_check
   import seg_pkg::*;
(
   input  desc_t             desc,
   input  logic              is_null,
   input  logic              idx_oob,
   input  logic [ADDR_W-1:0] off,
   input  acc_e              kind,
   input  logic [1:0]        cpl,
   input  logic [1:0]        rpl,
   output fault_e            fault,
   output logic [ADDR_W-1:0] lin
);
   logic       rights_ok;
   logic [1:0] eff_pl;

   always_comb begin
      unique case (kind)
         ACC_READ:  rights_ok = desc.rd;
         ACC_WRITE: rights_ok = desc.wr;
         ACC_EXEC:  rights_ok = desc.ex;
         default:   rights_ok = 1'b0;
      endcase
   end

   assign eff_pl = (cpl > rpl) ? cpl : rpl;

   always_comb begin
      if (is_null)                      fault = FLT_NULL;
      else if (idx_oob || off > desc.limit) fault = FLT_LIMIT;
      else if (!rights_ok)              fault = FLT_RIGHTS;
      else if (eff_pl > desc.dpl)       fault = FLT_PRIV;
      else                              fault = FLT_NONE;
   end

   assign lin = (fault == FLT_NONE) ? desc.base + off : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_pkg::*;
#(
   parameter int ENTRIES = 16,
   localparam int IDX_W = $clog2(ENTRIES),
   localparam int SEL_IDX_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_local,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] cfg_limit,
   input  logic              cfg_rd,
   input  logic              cfg_wr,
   input  logic              cfg_ex,
   input  logic [1:0]        cfg_dpl,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [15:0]       req_sel,
   input  logic [ADDR_W-1:0] req_off,
   input  logic [1:0]        req_kind,
   input  logic [1:0]        req_cpl,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [2:0]        rsp_fault
);
   if (ENTRIES < 2 || ENTRIES > (1 << SEL_IDX_W) || (1 << IDX_W) != ENTRIES) begin : g_bad_depth
      $error("seg_xlate: ENTRIES must be a power of two from 2 to 8192");
   end

   desc_t            new_desc, gdesc, ldesc, sel_desc;
   logic [IDX_W-1:0] rd_idx;
   logic             tbl_local, is_null, idx_oob, accept;
   fault_e           fault;
   logic [ADDR_W-1:0] lin;

   assign new_desc  = '{base: cfg_base, limit: cfg_limit, rd: cfg_rd,
                        wr: cfg_wr, ex: cfg_ex, dpl: cfg_dpl};
   assign tbl_local = req_sel[2];
   assign rd_idx    = req_sel[3 +: IDX_W];
   assign is_null   = (req_sel[15:2] == '0);

   if (IDX_W < SEL_IDX_W) begin : g_oob
      assign idx_oob = |req_sel[15:3+IDX_W];
   end else begin : g_no_oob
      assign idx_oob = 1'b0;
   end

   seg_desc_table #(.ENTRIES(ENTRIES)) u_gtab (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we && !cfg_local), .wr_idx(cfg_idx),
      .wr_desc(new_desc), .rd_idx(rd_idx), .rd_desc(gdesc));

   seg_desc_table #(.ENTRIES(ENTRIES)) u_ltab (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we && cfg_local), .wr_idx(cfg_idx),
      .wr_desc(new_desc), .rd_idx(rd_idx), .rd_desc(ldesc));

   assign sel_desc = tbl_local ? ldesc : gdesc;

   seg_rule_check u_chk (
      .desc(sel_desc), .is_null(is_null), .idx_oob(idx_oob), .off(req_off),
      .kind(acc_e'(req_kind)), .cpl(req_cpl), .rpl(req_sel[1:0]),
      .fault(fault), .lin(lin));

   assign req_ready = !rsp_valid || rsp_ready;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_addr  <= '0;
         rsp_fault <= FLT_NONE;
      end else if (accept) begin
         rsp_valid <= 1'b1;
         rsp_addr  <= lin;
         rsp_fault <= fault;
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

   assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> rsp_valid);
   assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault));
   assert_no_take_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |-> !req_ready);
   assert_fault_zero_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault != 3'd0 |-> rsp_addr == '0);
   assert_null_faults_R8: assert property (@(posedge clk) disable iff (!rst_n)
      accept && req_sel[15:2] == '0 |=> rsp_fault == 3'd4);
   assert_code_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_fault <= 3'd4);
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 0, cfg_local = 0, cfg_rd = 0, cfg_wr = 0, cfg_ex = 0;
   logic [3:0]  cfg_idx = '0;
   logic [31:0] cfg_base = '0, cfg_limit = '0;
   logic [1:0]  cfg_dpl = '0;
   logic        req_valid = 0, rsp_ready = 1;
   logic        req_ready, rsp_valid;
   logic [15:0] req_sel = '0;
   logic [31:0] req_off = '0;
   logic [1:0]  req_kind = '0, req_cpl = '0;
   logic [31:0] rsp_addr;
   logic [2:0]  rsp_fault;
   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   seg_xlate u0 (.*);

   task automatic check(string r, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic load(logic loc, logic [3:0] idx, logic [31:0] base, logic [31:0] lim,
                       logic rd, logic wr, logic ex, logic [1:0] dpl);
      @(negedge clk);
      cfg_we = 1; cfg_local = loc; cfg_idx = idx; cfg_base = base; cfg_limit = lim;
      cfg_rd = rd; cfg_wr = wr; cfg_ex = ex; cfg_dpl = dpl;
      @(posedge clk);
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic xlate(string r, logic [15:0] sel, logic [31:0] off, logic [1:0] kind,
                        logic [1:0] cpl, logic [31:0] ea, logic [2:0] ef);
      @(negedge clk);
      req_valid = 1; req_sel = sel; req_off = off; req_kind = kind; req_cpl = cpl;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      check({r, " valid"}, {31'd0, rsp_valid}, 32'd1);
      check({r, " addr"}, rsp_addr, ea);
      check({r, " fault"}, {29'd0, rsp_fault}, {29'd0, ef});
   endtask

   task automatic t_reset;
      check("R1 rsp_valid", {31'd0, rsp_valid}, 0);
      check("R1 req_ready", {31'd0, req_ready}, 1);
   endtask

   task automatic t_basic;
      load(0, 1, 32'h0000_1000, 32'h0000_0FFF, 1, 1, 0, 3);
      xlate("R2 global read", 16'h000B, 32'h10, 0, 3, 32'h0000_1010, 0);
      load(1, 1, 32'h8000_0000, 32'h0000_FFFF, 1, 0, 0, 3);
      xlate("R3 local idx1", 16'h000F, 32'h20, 0, 3, 32'h8000_0020, 0);
      load(1, 0, 32'h0000_4000, 32'h0000_00FF, 1, 0, 0, 3);
      xlate("R3 local idx0 not null", 16'h0007, 32'h10, 0, 3, 32'h0000_4010, 0);
   endtask

   task automatic t_limit;
      xlate("R4 offset at limit", 16'h000B, 32'h0FFF, 1, 3, 32'h0000_1FFF, 0);
      xlate("R4 offset above limit R11", 16'h000B, 32'h1000, 1, 3, 0, 1);
      xlate("R5 index 16", 16'h0083, 32'h0, 0, 0, 0, 1);
      xlate("R5 index 20 local", 16'h00A7, 32'h0, 0, 0, 0, 1);
   endtask

   task automatic t_rights;
      load(0, 2, 32'hFFFF_F000, 32'hFFFF_FFFF, 1, 1, 1, 3);
      xlate("R6 write to read-only", 16'h000F, 32'h0, 1, 3, 0, 2);
      xlate("R6 exec on rw", 16'h000B, 32'h0, 2, 3, 0, 2);
      xlate("R6 exec allowed", 16'h0013, 32'h4, 2, 3, 32'hFFFF_F004, 0);
      xlate("R6 reserved kind", 16'h0013, 32'h4, 3, 3, 0, 2);
      xlate("R12 wraparound", 16'h0013, 32'h2000, 0, 3, 32'h0000_1000, 0);
   endtask

   task automatic t_priv;
      load(0, 4, 32'h0000_9000, 32'h0000_00FF, 1, 0, 0, 0);
      xlate("R7 rpl too high", 16'h0023, 32'h8, 0, 0, 0, 3);
      xlate("R7 cpl too high", 16'h0020, 32'h8, 0, 3, 0, 3);
      xlate("R7 both zero", 16'h0020, 32'h8, 0, 0, 32'h0000_9008, 0);
      load(0, 5, 32'h0000_A000, 32'h0000_00FF, 1, 0, 0, 2);
      xlate("R7 equal level", 16'h002A, 32'h1, 0, 1, 32'h0000_A001, 0);
   endtask

   task automatic t_null;
      load(0, 0, 32'h0000_5000, 32'hFFFF_FFFF, 1, 1, 1, 3);
      xlate("R8 null rpl3", 16'h0003, 32'h0, 0, 0, 0, 4);
      xlate("R8 null rpl0", 16'h0000, 32'h10, 1, 0, 0, 4);
   endtask

   task automatic t_priority;
      load(0, 3, 32'h0000_0100, 32'h0000_000F, 0, 0, 0, 0);
      xlate("R9 limit over rights/priv", 16'h001B, 32'h20, 1, 3, 0, 1);
      xlate("R9 rights over priv", 16'h001B, 32'h4, 1, 3, 0, 2);
      xlate("R9 write rights over priv", 16'h0020, 32'h4, 1, 3, 0, 2);
   endtask

   task automatic t_backpressure;
      @(negedge clk);
      rsp_ready = 0;
      req_valid = 1; req_sel = 16'h000B; req_off = 32'h44; req_kind = 0; req_cpl = 3;
      @(posedge clk);
      @(negedge clk);
      req_sel = 16'h000F; req_off = 32'h8;
      check("R10 ready low while held", {31'd0, req_ready}, 0);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check("R10 held valid", {31'd0, rsp_valid}, 1);
      check("R10 held addr", rsp_addr, 32'h0000_1044);
      check("R10 ready still low", {31'd0, req_ready}, 0);
      rsp_ready = 1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      check("R10 next valid", {31'd0, rsp_valid}, 1);
      check("R10 next addr", rsp_addr, 32'h8000_0008);
      @(posedge clk);
      @(negedge clk);
      check("R10 drained", {31'd0, rsp_valid}, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1;
      t_basic();
      t_limit();
      t_rights();
      t_priv();
      t_null();
      t_priority();
      t_backpressure();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #400000;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule